// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block is a 32-bit arithmetic unit for signal-processing datapaths that must not wrap around on overflow. A 4-bit opcode selects the operation. There are signed and unsigned saturating add and subtract, and an add that only reports overflow. There is also a clamp of one operand to a programmable bit position, in a full-word form and in a two-lane form that treats each 16-bit half as its own signed number.

Each operation is presented with a one-cycle `valid_i` strobe. The result appears on a register one cycle later and holds until the next valid operation. A sticky flag records that some operation since the last clear had to clamp or overflowed. Software-visible clearing is the job of the surrounding logic, which drives `clr_i`.

Top module: `sat_alu`

## Requirements
- R1: A synchronous active-high `rst` drives `result_o` to 0 and `sticky_o` to 0 at the next rising edge.
- R2: Opcode 1 (signed saturating add) returns a+b. On signed overflow it returns 0x7FFFFFFF when a is non-negative and 0x80000000 when a is negative. Signed overflow means both operands share a sign and the sum's sign differs from it.
- R3: Opcode 2 (signed saturating subtract) returns a−b. It overflows when the operands differ in sign and the difference's sign differs from a's sign. It then clamps to 0x7FFFFFFF when a is non-negative and to 0x80000000 otherwise.
- R4: Opcode 3 (unsigned saturating add) returns 0xFFFFFFFF when the sum carries out. Opcode 4 (unsigned saturating subtract) returns 0 when b > a.
- R5: Opcode 0 (overflow-reporting add) always returns the wrapped 32-bit sum. It sets the sticky flag under the signed-overflow rule of R2.
- R6: Opcode 5 (signed clamp) limits the signed value of a to the range −2^n … 2^n−1, where n = `pos_i` (0..31).
- R7: Opcode 6 (unsigned clamp) returns 0 for a negative signed a. It returns 2^n−1 for a above 2^n−1, with n = `pos_i`.
- R8: Opcodes 7 and 8 are the signed and unsigned clamps of R6 and R7 applied to each signed 16-bit half of a on its own. The lower-half result goes to bits 15:0 and the upper-half result to bits 31:16.
- R9: The sticky flag is set at the edge that registers any clamping or overflowing operation. An operation that does not clamp leaves the flag unchanged.
- R10: `clr_i` resets the sticky flag at the next edge. If a clamping valid operation arrives in the same cycle, the flag ends up set.
- R11: `result_o` changes exactly one cycle after a cycle with `valid_i` high and holds its value while `valid_i` is low. Operand b is ignored by opcodes 5–8.
- R12: Opcodes 9–15 return 0 and leave the sticky flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| clr_i | input | 1 | Sticky flag clear |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand / value to clamp |
| b_i | input | 32 | Second operand |
| pos_i | input | 5 | Clamp bit position n |
| result_o | output | 32 | Registered result |
| sticky_o | output | 1 | Sticky saturation flag |

## Verification
Some properties are checked on every cycle. The flag stays set until cleared. A clear without a clamping operation drops the flag. The result is stable on idle cycles. Unsigned saturating add never returns less than a, and unsigned saturating subtract never returns more than a. The wrapped sum of the reporting add always matches the operands. The exact clamp values, the per-half independence of the dual forms, the position-0 and position-31 boundaries, and the clear-versus-set collision depend on specific operand patterns. Only the bench's directed and random scenarios against its behavioural model show those.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_REPORT = 4'd0,
        OP_SADD       = 4'd1,
        OP_SSUB       = 4'd2,
        OP_UADD       = 4'd3,
        OP_USUB       = 4'd4,
        OP_SCLAMP     = 4'd5,
        OP_UCLAMP     = 4'd6,
        OP_SCLAMP2    = 4'd7,
        OP_UCLAMP2    = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARITH = 2'd1,
        SRC_WORD  = 2'd2,
        SRC_DUAL  = 2'd3
    } src_e;

    typedef struct packed {
        src_e src;
        logic is_sub;
        logic is_signed;
        logic do_clamp;
    } ctl_t;

    function automatic ctl_t decode_op(logic [OP_W-1:0] op);
        ctl_t c;
        c = '{src: SRC_NONE, is_sub: 1'b0, is_signed: 1'b0, do_clamp: 1'b0};
        case (op)
            OP_ADD_REPORT: c = '{src: SRC_ARITH, is_sub: 1'b0, is_signed: 1'b1, do_clamp: 1'b0};
            OP_SADD:       c = '{src: SRC_ARITH, is_sub: 1'b0, is_signed: 1'b1, do_clamp: 1'b1};
            OP_SSUB:       c = '{src: SRC_ARITH, is_sub: 1'b1, is_signed: 1'b1, do_clamp: 1'b1};
            OP_UADD:       c = '{src: SRC_ARITH, is_sub: 1'b0, is_signed: 1'b0, do_clamp: 1'b1};
            OP_USUB:       c = '{src: SRC_ARITH, is_sub: 1'b1, is_signed: 1'b0, do_clamp: 1'b1};
            OP_SCLAMP:     c = '{src: SRC_WORD,  is_sub: 1'b0, is_signed: 1'b1, do_clamp: 1'b1};
            OP_UCLAMP:     c = '{src: SRC_WORD,  is_sub: 1'b0, is_signed: 1'b0, do_clamp: 1'b1};
            OP_SCLAMP2:    c = '{src: SRC_DUAL,  is_sub: 1'b0, is_signed: 1'b1, do_clamp: 1'b1};
            OP_UCLAMP2:    c = '{src: SRC_DUAL,  is_sub: 1'b0, is_signed: 1'b0, do_clamp: 1'b1};
            default:       c = '{src: SRC_NONE,  is_sub: 1'b0, is_signed: 1'b0, do_clamp: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         is_sub,
    input  logic         is_signed,
    output logic [W-1:0] wrapped,
    output logic [W-1:0] limit,
    output logic         ovf
);
    logic [W:0] ext;
    logic       s_ovf;

    always_comb begin
        if (is_sub) ext = {1'b0, a} - {1'b0, b};
        else        ext = {1'b0, a} + {1'b0, b};
        wrapped = ext[W-1:0];

        if (is_sub) s_ovf = (a[W-1] != b[W-1]) && (wrapped[W-1] != a[W-1]);
        else        s_ovf = (a[W-1] == b[W-1]) && (wrapped[W-1] != a[W-1]);

        if (is_signed) begin
            ovf   = s_ovf;
            limit = a[W-1] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end else begin
            ovf   = ext[W];
            limit = is_sub ? '0 : '1;
        end
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W     = 32,
    parameter int POS_W = 5
) (
    input  logic [W-1:0]     val,
    input  logic [POS_W-1:0] pos,
    input  logic             is_signed,
    output logic [W-1:0]     res,
    output logic             hit
);
    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] hi_lim;
    logic         wide;

    always_comb begin
        wide   = (int'(pos) >= W - 1);
        hi_lim = wide ? MAX_POS : ((W'(1) << pos) - W'(1));
        res    = val;
        hit    = 1'b0;
        if (is_signed) begin
            if ($signed(val) > $signed(hi_lim)) begin
                res = hi_lim;
                hit = 1'b1;
            end else if ($signed(val) < $signed(~hi_lim)) begin
                res = ~hi_lim;
                hit = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res = '0;
                hit = 1'b1;
            end else if (val > hi_lim) begin
                res = hi_lim;
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      valid_i,
    input  logic                      clr_i,
    input  logic [OP_W-1:0]           op_i,
    input  logic [DATA_W-1:0]         a_i,
    input  logic [DATA_W-1:0]         b_i,
    input  logic [$clog2(DATA_W)-1:0] pos_i,
    output logic [DATA_W-1:0]         result_o,
    output logic                      sticky_o
);
    localparam int POS_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;
    localparam int LANES  = 2;

    ctl_t                          ctl;
    logic [DATA_W-1:0]             arith_wrap, arith_lim, word_res, next_res;
    logic                          arith_ovf, word_hit, next_hit;
    logic [LANES-1:0][HALF_W-1:0]  lane_res;
    logic [LANES-1:0]              lane_hit;
    logic [DATA_W-1:0]             res_q;
    logic                          flag_q;

    assign ctl = decode_op(op_i);

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a(a_i), .b(b_i), .is_sub(ctl.is_sub), .is_signed(ctl.is_signed),
        .wrapped(arith_wrap), .limit(arith_lim), .ovf(arith_ovf)
    );

    sat_clamp #(.W(DATA_W), .POS_W(POS_W)) u_word (
        .val(a_i), .pos(pos_i), .is_signed(ctl.is_signed),
        .res(word_res), .hit(word_hit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(HALF_W), .POS_W(POS_W)) u_half (
            .val(a_i[g*HALF_W +: HALF_W]), .pos(pos_i), .is_signed(ctl.is_signed),
            .res(lane_res[g]), .hit(lane_hit[g])
        );
    end

    always_comb begin
        next_res = '0;
        next_hit = 1'b0;
        case (ctl.src)
            SRC_ARITH: begin
                next_hit = arith_ovf;
                next_res = (arith_ovf && ctl.do_clamp) ? arith_lim : arith_wrap;
            end
            SRC_WORD: begin
                next_hit = word_hit;
                next_res = word_res;
            end
            SRC_DUAL: begin
                next_hit = |lane_hit;
                next_res = lane_res;
            end
            default: begin
                next_hit = 1'b0;
                next_res = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (valid_i) res_q <= next_res;
            if (valid_i && next_hit) flag_q <= 1'b1;
            else if (clr_i)          flag_q <= 1'b0;
        end
    end

    assign result_o = res_q;
    assign sticky_o = flag_q;

    AST_RESET_STATE: assert property (@(posedge clk) rst |=> (result_o == '0 && !sticky_o)); // R1
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) (sticky_o && !clr_i) |=> sticky_o); // R9
    AST_NO_SET_IDLE: assert property (@(posedge clk) disable iff (rst) (!sticky_o && !valid_i) |=> !sticky_o); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst) (clr_i && !valid_i) |=> !sticky_o); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !valid_i |=> $stable(result_o)); // R11
    AST_UADD_FLOOR: assert property (@(posedge clk) disable iff (rst) (valid_i && op_i == OP_UADD) |=> (result_o >= $past(a_i))); // R4
    AST_USUB_CEIL: assert property (@(posedge clk) disable iff (rst) (valid_i && op_i == OP_USUB) |=> (result_o <= $past(a_i))); // R4
    AST_REPORT_WRAPS: assert property (@(posedge clk) disable iff (rst) (valid_i && op_i == OP_ADD_REPORT) |=> (result_o == $past(a_i) + $past(b_i))); // R5
    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst) (valid_i && op_i > OP_UCLAMP2) |=> (result_o == '0)); // R12
endmodule

// File: tb/sat_alu_test.sv
module sat_alu_test;
    logic        clk = 1'b0;
    logic        rst, valid, clr;
    logic [3:0]  op;
    logic [31:0] a, b;
    logic [4:0]  pos;
    logic [31:0] result;
    logic        sticky;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] exp_res;
    logic        exp_flag;

    always #2 clk = ~clk;

    sat_alu uut (
        .clk(clk), .rst(rst), .valid_i(valid), .clr_i(clr), .op_i(op),
        .a_i(a), .b_i(b), .pos_i(pos), .result_o(result), .sticky_o(sticky)
    );

    function automatic longint clamp_s(longint v, int n, inout bit h);
        longint hi = (longint'(1) << n) - 1;
        longint lo = -(longint'(1) << n);
        if (v > hi) begin h = 1; return hi; end
        if (v < lo) begin h = 1; return lo; end
        return v;
    endfunction

    function automatic longint clamp_u(longint v, int n, inout bit h);
        longint hi = (longint'(1) << n) - 1;
        if (v < 0)  begin h = 1; return 0; end
        if (v > hi) begin h = 1; return hi; end
        return v;
    endfunction

    function automatic logic [32:0] model(int o, logic [31:0] x, logic [31:0] y, int n);
        bit          h = 0;
        longint      sx = longint'($signed(x));
        longint      sy = longint'($signed(y));
        longint      ux = longint'({32'd0, x});
        longint      uy = longint'({32'd0, y});
        longint      t, lo16, hi16;
        logic [63:0] r = '0;
        logic [63:0] rl, rh;
        case (o)
            0: begin t = sx + sy; h = (t > 64'sd2147483647) || (t < -64'sd2147483648); r = ux + uy; end
            1, 2: begin
                t = (o == 1) ? sx + sy : sx - sy;
                if (t > 64'sd2147483647)       begin h = 1; r = 64'h7FFFFFFF; end
                else if (t < -64'sd2147483648) begin h = 1; r = 64'h80000000; end
                else r = t;
            end
            3: begin t = ux + uy; if (t > 64'hFFFFFFFF) begin h = 1; r = 64'hFFFFFFFF; end else r = t; end
            4: begin t = ux - uy; if (t < 0) begin h = 1; r = 0; end else r = t; end
            5: r = clamp_s(sx, n, h);
            6: r = clamp_u(sx, n, h);
            7, 8: begin
                lo16 = longint'($signed(x[15:0]));
                hi16 = longint'($signed(x[31:16]));
                rl = (o == 7) ? clamp_s(lo16, n, h) : clamp_u(lo16, n, h);
                rh = (o == 7) ? clamp_s(hi16, n, h) : clamp_u(hi16, n, h);
                r  = {32'd0, rh[15:0], rl[15:0]};
            end
            default: r = '0;
        endcase
        return {h, r[31:0]};
    endfunction

    function automatic string tag_of(int o);
        case (o)
            0: return "R5";
            1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5: return "R6";
            6: return "R7";
            7, 8: return "R8";
            default: return "R12";
        endcase
    endfunction

    task automatic step(input bit r, input bit v, input bit c, input int o,
                        input logic [31:0] x, input logic [31:0] y, input int n, input string tag);
        logic [32:0] m;
        @(negedge clk);
        rst = r; valid = v; clr = c; op = 4'(o); a = x; b = y; pos = 5'(n);
        m = model(o, x, y, n);
        if (r) begin
            exp_res = '0; exp_flag = 0;
        end else begin
            if (v) exp_res = m[31:0];
            if (v && m[32]) exp_flag = 1;
            else if (c)     exp_flag = 0;
        end
        @(posedge clk);
        #1;
        n_cmp++;
        if (result !== exp_res || sticky !== exp_flag) begin
            n_bad++;
            $display("FAIL %s: op=%0d a=%h b=%h n=%0d got res=%h flag=%b expected res=%h flag=%b",
                     tag, o, x, y, n, result, sticky, exp_res, exp_flag);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1; valid = 0; clr = 0; op = 0; a = 0; b = 0; pos = 0;
        exp_res = 'x; exp_flag = 'x;
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 0, 1, 32'h7FFFFFFF, 32'h1, 0, "R1");
        step(0, 0, 0, 0, 0, 0, 0, "R1");
        // R5: wraps but flags
        step(0, 1, 0, 0, 32'h7FFFFFFF, 32'h1, 0, "R5");
        step(0, 1, 1, 0, 32'h0000_0003, 32'h4, 0, "R10");
        // R2
        step(0, 1, 0, 1, 32'h7FFFFFF0, 32'h100, 0, "R2");
        step(0, 0, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 1, 32'h80000010, 32'hFFFFFF00, 0, "R2");
        step(0, 0, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 1, 32'h00000005, 32'hFFFFFFF9, 0, "R9");
        // R3
        step(0, 1, 0, 2, 32'h80000000, 32'h1, 0, "R3");
        step(0, 0, 1, 0, 0, 0, 0, "R10");
        step(0, 1, 0, 2, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, "R3");
        step(0, 1, 1, 2, 32'h5, 32'h7, 0, "R3");
        // R4
        step(0, 1, 0, 3, 32'hFFFFFFF0, 32'h20, 0, "R4");
        step(0, 1, 1, 4, 32'h3, 32'h5, 0, "R4");
        step(0, 1, 1, 4, 32'h9, 32'h5, 0, "R4");
        // R6 with b ignored (R11)
        step(0, 1, 1, 5, 32'd300, 32'hDEADBEEF, 7, "R6");
        step(0, 1, 1, 5, 32'hFFFFFED4, 32'h0, 7, "R6");
        step(0, 1, 1, 5, 32'd5, 32'h0, 0, "R6");
        step(0, 1, 1, 5, 32'hFFFFFFFF, 32'h12345678, 0, "R11");
        step(0, 1, 1, 5, 32'h80000000, 32'h0, 31, "R6");
        // R7
        step(0, 1, 1, 6, 32'hFFFFFFFB, 32'h0, 8, "R7");
        step(0, 1, 1, 6, 32'd1000, 32'h0, 8, "R7");
        step(0, 1, 1, 6, 32'h7FFFFFFF, 32'h0, 31, "R7");
        // R8
        step(0, 1, 1, 7, 32'h80000100, 32'h0, 7, "R8");
        step(0, 1, 1, 7, 32'h00050005, 32'h0, 7, "R8");
        step(0, 1, 1, 8, 32'hFFFF0005, 32'h0, 3, "R8");
        step(0, 1, 1, 8, 32'h7FFF8000, 32'h0, 20, "R8");
        // R10: set wins over clear
        step(0, 1, 1, 3, 32'hFFFFFFFF, 32'h1, 0, "R10");
        // R11: hold
        step(0, 0, 0, 1, 32'h1, 32'h1, 0, "R11");
        step(0, 0, 0, 2, 32'h2, 32'h2, 0, "R11");
        // R12
        step(0, 1, 0, 12, 32'hFFFFFFFF, 32'hFFFFFFFF, 5, "R12");
        step(0, 1, 1, 15, 32'h1, 32'h1, 5, "R10");
        step(0, 1, 0, 9, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, "R12");
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            int o;
            o = $urandom_range(0, 10);
            step(0, ($urandom_range(0, 3) != 0), ($urandom_range(0, 7) == 0), o,
                 $urandom(), ($urandom_range(0, 1) != 0) ? $urandom() : 32'($urandom_range(0, 300)),
                 $urandom_range(0, 31), tag_of(o));
        end
        step(1, 0, 0, 0, 0, 0, 0, "R1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule